// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit processor pipeline and a 32-bit external data bus that always moves whole words. For a store it copies a byte, half-word or word operand into the bus lanes and drives a four-bit lane-enable mask. Only the enabled bytes of memory change. For a load it issues the same word-aligned request. When the bus later returns the full word, the unit picks out the addressed byte or half-word and widens it to 32 bits, using sign extension or zero extension as the request asks.

A configuration input selects, at run time, whether byte 0 of a word sits in the least significant lane (little-endian) or the most significant lane (big-endian). An access whose address is not a multiple of its size is not split or rotated. It raises an address-error output and produces no bus request. Request-side outputs are combinational. The load result is registered on the cycle the bus returns data, using the size, offset, signedness and lane order that were captured when the request was issued. Only one load may be outstanding at a time.

Top module: `lsu_lane_align`

## Requirements
- R1: An accepted access drives `bus_req` high, `bus_we` equal to `req_write`, and `bus_addr` equal to `req_addr` with bits [1:0] cleared.
- R2: A half-word access (`req_size`=1) with `req_addr[0]`=1 raises `addr_err`. It keeps `bus_req` low and `bus_be` at zero.
- R3: A word access (`req_size`=2) with `req_addr[1:0]`≠0 raises `addr_err` and issues no request. The reserved size code 3 is treated the same way at any address.
- R4: In little-endian mode (`cfg_big_endian`=0), a byte access enables lane `req_addr[1:0]`. A half-word access enables lanes {1,0} when `req_addr[1]`=0 and lanes {3,2} when it is 1. A word access enables all four lanes. Lane n is `bus_wdata`/`bus_rdata` bits [8n+7:8n].
- R5: In big-endian mode (`cfg_big_endian`=1), a byte access enables lane 3−`req_addr[1:0]`. A half-word access enables lanes {3,2} when `req_addr[1]`=0 and lanes {1,0} when it is 1.
- R6: On a store, `bus_wdata` holds the operand's low byte in every lane for a byte access, the low half-word in both halves for a half-word access, and the operand unchanged for a word access.
- R7: A byte load returns the enabled lane's byte, sign-extended when `req_signed`=1 and zero-extended when it is 0.
- R8: A half-word load returns bus bits [31:16] when the enabled lanes are {3,2}, and bits [15:0] when they are {1,0}. It is sign- or zero-extended as in R7.
- R9: A word load returns the bus word unchanged, whatever `req_signed` is.
- R10: `ld_valid` is high exactly in the cycle after `bus_rvalid` is high. The result uses the lane order captured with the request, so a change of `cfg_big_endian` after the request does not affect it.
- R11: After reset, `ld_valid` and `ld_data` are zero. While `req_valid` is low, `bus_req` and `addr_err` are low.
- R12: A byte access never raises `addr_err`, at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_big_endian | input | 1 | 1 selects big-endian lane order |
| req_valid | input | 1 | Access request from pipeline |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store operand, right-justified |
| addr_err | output | 1 | Misaligned or illegal access |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus write strobe |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_be | output | 4 | Lane enables |
| bus_wdata | output | 32 | Lane-placed store data |
| bus_rvalid | input | 1 | Bus read data valid |
| bus_rdata | input | 32 | Bus read word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bound checker evaluates the request-side rules on every cycle. These rules are: no request is issued while an address error is raised, misaligned half-words and words and the reserved size always raise the error, byte accesses never do, the number of enabled lanes matches the access size, and the one-cycle link from `bus_rvalid` to `ld_valid` holds. Which lanes are enabled for a given endianness, how store data is replicated, and the value and extension of each extracted load can only be shown by the bench scenarios. These scenarios compare against an independent model and include a change of lane order between request and data return.

// File: rtl/lsu_align_pkg.sv
// Shared types and helpers for the load/store lane alignment unit.
// Assumes a byte-addressed bus whose width is a whole number of bytes.
package lsu_align_pkg;

    localparam int BUS_W      = 32;
    localparam int LANES      = BUS_W / 8;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int HALF_W     = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Load context captured at request time, consumed when data returns.
    typedef struct packed {
        logic                  big_end;
        logic [LANE_IDX_W-1:0] lo;
        acc_size_e             size;
        logic                  sext;
    } ld_ctx_t;

    // Lowest-numbered lane touched by an aligned access.
    function automatic logic [LANE_IDX_W-1:0] base_lane(
        input acc_size_e             size,
        input logic [LANE_IDX_W-1:0] lo,
        input logic                  big_end
    );
        logic [LANE_IDX_W-1:0] even;
        even = {lo[LANE_IDX_W-1:1], 1'b0};
        unique case (size)
            SZ_BYTE: base_lane = big_end ? LANE_IDX_W'(LANES - 1) - lo : lo;
            SZ_HALF: base_lane = big_end ? LANE_IDX_W'(LANES - 2) - even : even;
            default: base_lane = '0;
        endcase
    endfunction

endpackage

// File: rtl/lsu_align_check.sv
// Alignment checker: decides whether a request is legal for its size.
// Assumes the pipeline holds the request stable for the whole cycle.
module lsu_align_check
    import lsu_align_pkg::*;
(
    input  logic                  req_valid,
    input  acc_size_e             size,
    input  logic [LANE_IDX_W-1:0] lo,
    output logic                  addr_err,
    output logic                  go
);

    logic misaligned;

    // Classify the offset against the natural alignment of each size.
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = lo[0];
            SZ_WORD: misaligned = |lo;
            default: misaligned = 1'b1;
        endcase
    end

    // Raise the error or release the request, never both.
    always_comb begin
        addr_err = req_valid &  misaligned;
        go       = req_valid & ~misaligned;
    end

endmodule

// File: rtl/lsu_store_lanes.sv
// Store lane placement: builds the lane-enable mask and replicates the
// store operand across all lanes. Assumes the request is already known
// to be aligned whenever go is high.
module lsu_store_lanes
    import lsu_align_pkg::*;
(
    input  logic                  go,
    input  acc_size_e             size,
    input  logic [LANE_IDX_W-1:0] lo,
    input  logic                  big_end,
    input  logic [BUS_W-1:0]      wdata_in,
    output logic [LANES-1:0]      be,
    output logic [BUS_W-1:0]      wdata_out
);

    logic [LANE_IDX_W-1:0] first;
    logic [LANES-1:0]      mask;

    // Locate the first lane of the access for the current lane order.
    always_comb first = base_lane(size, lo, big_end);

    // Expand the first lane into a mask of width matching the size.
    always_comb begin
        mask = '0;
        unique case (size)
            SZ_BYTE: mask[first]      = 1'b1;
            SZ_HALF: mask[first +: 2] = 2'b11;
            default: mask             = '1;
        endcase
    end

    // Drive enables only while a transfer is actually requested.
    always_comb be = go ? mask : '0;

    // Replicate the operand so the enables alone pick the written bytes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata_out[g*8 +: 8] = wdata_in[7:0];
                SZ_HALF: wdata_out[g*8 +: 8] = wdata_in[(g % 2)*8 +: 8];
                default: wdata_out[g*8 +: 8] = wdata_in[g*8 +: 8];
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
// Load extraction: keeps the context of the outstanding load, then on
// returned bus data selects the addressed lanes and extends them.
// Assumes at most one load outstanding and data returning in a later
// cycle than the request.
module lsu_load_extract
    import lsu_align_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  ld_ctx_t          ctx_in,
    input  logic             rvalid,
    input  logic [BUS_W-1:0] rdata,
    output logic             ld_valid,
    output logic [BUS_W-1:0] ld_data
);

    ld_ctx_t               ctx_q;
    logic [LANE_IDX_W-1:0] first;
    logic [7:0]            byte_v;
    logic [HALF_W-1:0]     half_v;
    logic [BUS_W-1:0]      ext_v;

    // Hold the request attributes until the bus answers.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctx_q <= '0;
        else if (capture) ctx_q <= ctx_in;
    end

    // Locate the lanes of the stored access.
    always_comb first = base_lane(ctx_q.size, ctx_q.lo, ctx_q.big_end);

    // Pull the byte and half-word out of the returned word.
    always_comb begin
        byte_v = rdata[first*8 +: 8];
        half_v = rdata[first*8 +: HALF_W];
    end

    // Widen the selected item to the full bus width.
    always_comb begin
        unique case (ctx_q.size)
            SZ_BYTE: ext_v = ctx_q.sext ? {{(BUS_W-8){byte_v[7]}}, byte_v}
                                        : {{(BUS_W-8){1'b0}}, byte_v};
            SZ_HALF: ext_v = ctx_q.sext ? {{(BUS_W-HALF_W){half_v[HALF_W-1]}}, half_v}
                                        : {{(BUS_W-HALF_W){1'b0}}, half_v};
            default: ext_v = rdata;
        endcase
    end

    // Register the result in the cycle the bus returns data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= rvalid;
            if (rvalid) ld_data <= ext_v;
        end
    end

endmodule

// File: rtl/lsu_lane_align.sv
// Top of the load/store byte-lane alignment unit. Request-side outputs
// are combinational from the request; the load result is registered.
// Assumes the bus accepts any request in the cycle it is presented.
module lsu_lane_align
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_endian,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              addr_err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANES-1:0]  bus_be,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rvalid,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic              ld_valid,
    output logic [BUS_W-1:0]  ld_data
);

    acc_size_e             size;
    logic [LANE_IDX_W-1:0] lo;
    logic                  go;
    ld_ctx_t               ctx;

    // Decode the request fields.
    always_comb begin
        size = acc_size_e'(req_size);
        lo   = req_addr[LANE_IDX_W-1:0];
    end

    lsu_align_check u_check (
        .req_valid (req_valid),
        .size      (size),
        .lo        (lo),
        .addr_err  (addr_err),
        .go        (go)
    );

    lsu_store_lanes u_store (
        .go        (go),
        .size      (size),
        .lo        (lo),
        .big_end   (cfg_big_endian),
        .wdata_in  (req_wdata),
        .be        (bus_be),
        .wdata_out (bus_wdata)
    );

    // Present the word-aligned bus request.
    always_comb begin
        bus_req  = go;
        bus_we   = go & req_write;
        bus_addr = {req_addr[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};
    end

    // Bundle the attributes a returning load will need.
    always_comb begin
        ctx.big_end = cfg_big_endian;
        ctx.lo      = lo;
        ctx.size    = size;
        ctx.sext    = req_signed;
    end

    lsu_load_extract u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (go & ~req_write),
        .ctx_in   (ctx),
        .rvalid   (bus_rvalid),
        .rdata    (bus_rdata),
        .ld_valid (ld_valid),
        .ld_data  (ld_data)
    );

endmodule

// File: rtl/lsu_lane_align_chk.sv
// Checker bound to lsu_lane_align: cycle-by-cycle rules on the request
// side and on the load-return timing.
module lsu_lane_align_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_size,
    input logic [1:0] addr_lo,
    input logic       addr_err,
    input logic       bus_req,
    input logic [3:0] bus_be,
    input logic       bus_rvalid,
    input logic       ld_valid
);

    // R2 R3
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_err && bus_req));

    // R2
    half_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd1 && addr_lo[0]) |-> (addr_err && bus_be == 4'b0));

    // R3
    word_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size == 2'd3 || (req_size == 2'd2 && addr_lo != 2'd0))) |-> addr_err);

    // R12
    byte_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |-> (bus_req && !addr_err));

    // R4 R5
    lane_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be) == (1 << req_size)));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!bus_req && !addr_err && bus_be == 4'b0));

    // R10
    ld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> ld_valid);

    // R10
    ld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |=> !ld_valid);

endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_size   (req_size),
    .addr_lo    (req_addr[1:0]),
    .addr_err   (addr_err),
    .bus_req    (bus_req),
    .bus_be     (bus_be),
    .bus_rvalid (bus_rvalid),
    .ld_valid   (ld_valid)
);

// File: tb/lsu_lane_align_bench.sv
`timescale 1ns/1ps
module lsu_lane_align_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        addr_err, bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];

    always #2 clk = ~clk;

    lsu_lane_align u_lsu_lane_align (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Reference lane mask from R4/R5.
    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] a, input logic big);
        logic [1:0] l;
        case (sz)
            2'd0: begin l = big ? 2'd3 - a : a; ref_be = 4'b0001 << l; end
            2'd1: ref_be = (a[1] ^ big) ? 4'b1100 : 4'b0011;
            default: ref_be = 4'b1111;
        endcase
    endfunction

    // Reference load result from R7/R8/R9.
    function automatic logic [31:0] ref_ld(input logic [31:0] w, input logic [1:0] sz,
                                           input logic [1:0] a, input logic big, input logic s);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*(big ? 3 - a : a) +: 8];
        h = (a[1] ^ big) ? w[31:16] : w[15:0];
        case (sz)
            2'd0: ref_ld = s ? {{24{b[7]}}, b} : {24'h0, b};
            2'd1: ref_ld = s ? {{16{h[15]}}, h} : {16'h0, h};
            default: ref_ld = w;
        endcase
    endfunction

    task automatic do_store(input string tag, input logic big, input logic [1:0] sz,
                            input logic [31:0] a, input logic [31:0] d, input logic [31:0] exp_wd);
        @(negedge clk);
        cfg_big_endian = big; req_valid = 1; req_write = 1;
        req_size = sz; req_addr = a; req_wdata = d;
        #1;
        chk({tag, " R1 req"}, {31'b0, bus_req}, 32'd1);
        chk({tag, " R1 we"}, {31'b0, bus_we}, 32'd1);
        chk({tag, " R1 addr"}, bus_addr, {a[31:2], 2'b00});
        chk({tag, " be"}, {28'b0, bus_be}, {28'b0, ref_be(sz, a[1:0], big)});
        chk({tag, " R6 wdata"}, bus_wdata, exp_wd);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_bad(input string tag, input logic [1:0] sz, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_size = sz; req_addr = a;
        #1;
        chk({tag, " err"}, {31'b0, addr_err}, 32'd1);
        chk({tag, " noreq"}, {27'b0, bus_req, bus_be}, 32'd0);
        @(negedge clk);
        req_valid = 0;
    endtask

    // Driver: issues a load, pushes the expected result, then returns data.
    task automatic do_load(input logic big, input logic [1:0] sz, input logic [31:0] a,
                           input logic s, input logic [31:0] w, input logic flip);
        @(negedge clk);
        cfg_big_endian = big; req_valid = 1; req_write = 0;
        req_size = sz; req_addr = a; req_signed = s;
        #1;
        chk("R1 load req", {31'b0, bus_req}, 32'd1);
        chk(big ? "R5 load be" : "R4 load be", {28'b0, bus_be}, {28'b0, ref_be(sz, a[1:0], big)});
        exp_q.push_back(ref_ld(w, sz, a[1:0], big, s));
        @(negedge clk);
        req_valid = 0;
        if (flip) cfg_big_endian = ~big;
        bus_rvalid = 1; bus_rdata = w;
        @(negedge clk);
        bus_rvalid = 0; bus_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
    endtask

    // Monitor: every load result is compared with the queue head (R7-R10).
    always @(negedge clk) begin
        if (rst_n && ld_valid) begin
            if (exp_q.size() == 0) chk("R10 spurious ld_valid", 32'd1, 32'd0);
            else chk("R7 R8 R9 R10 ld_data", ld_data, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ld_valid", {31'b0, ld_valid}, 32'd0);
        chk("R11 ld_data", ld_data, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R11 idle", {30'b0, bus_req, addr_err}, 32'd0);

        // R4 little-endian byte stores at every offset
        for (int i = 0; i < 4; i++)
            do_store("R4 LE byte", 1'b0, 2'd0, 32'h1000_0040 + i, 32'h1234_56A5, 32'hA5A5_A5A5);
        // R5 big-endian byte stores
        for (int i = 0; i < 4; i++)
            do_store("R5 BE byte", 1'b1, 2'd0, 32'h2000_0000 + i, 32'h0000_003C, 32'h3C3C_3C3C);
        // R4 R5 half-word stores, R6 replication
        do_store("R4 LE half0", 1'b0, 2'd1, 32'h0000_0100, 32'hFFFF_BEEF, 32'hBEEF_BEEF);
        do_store("R4 LE half2", 1'b0, 2'd1, 32'h0000_0102, 32'h0000_1357, 32'h1357_1357);
        do_store("R5 BE half0", 1'b1, 2'd1, 32'h0000_0104, 32'h0000_2468, 32'h2468_2468);
        do_store("R5 BE half2", 1'b1, 2'd1, 32'h0000_0106, 32'hABCD_9876, 32'h9876_9876);
        do_store("R4 LE word", 1'b0, 2'd2, 32'hFFFF_FFFC, 32'hCAFE_F00D, 32'hCAFE_F00D);
        do_store("R5 BE word", 1'b1, 2'd2, 32'h0000_0008, 32'h0102_0304, 32'h0102_0304);

        // R2 R3 misaligned and reserved
        do_bad("R2 half odd 1", 2'd1, 32'h0000_0001);
        do_bad("R2 half odd 3", 2'd1, 32'h0000_0203);
        for (int i = 1; i < 4; i++) do_bad("R3 word off", 2'd2, 32'h0000_0300 + i);
        do_bad("R3 rsvd size", 2'd3, 32'h0000_0400);
        // R12 byte at odd address
        @(negedge clk);
        req_valid = 1; req_size = 2'd0; req_addr = 32'h0000_0003; req_write = 0;
        #1;
        chk("R12 byte no err", {30'b0, addr_err, bus_req}, 32'd1);
        @(negedge clk);
        req_valid = 0;

        // R7 byte loads
        for (int i = 0; i < 4; i++) begin
            do_load(1'b0, 2'd0, 32'h40 + i, 1'b1, 32'h80F1_7F22, 1'b0);
            do_load(1'b0, 2'd0, 32'h40 + i, 1'b0, 32'h80F1_7F22, 1'b0);
            do_load(1'b1, 2'd0, 32'h40 + i, 1'b1, 32'h80F1_7F22, 1'b0);
        end
        // R8 half-word loads
        do_load(1'b0, 2'd1, 32'h50, 1'b1, 32'h80F1_7F22, 1'b0);
        do_load(1'b0, 2'd1, 32'h52, 1'b1, 32'h80F1_7F22, 1'b0);
        do_load(1'b0, 2'd1, 32'h52, 1'b0, 32'h80F1_7F22, 1'b0);
        do_load(1'b1, 2'd1, 32'h50, 1'b1, 32'h80F1_7F22, 1'b0);
        do_load(1'b1, 2'd1, 32'h52, 1'b1, 32'h80F1_7F22, 1'b0);
        // R9 word loads, signedness ignored
        do_load(1'b0, 2'd2, 32'h60, 1'b1, 32'h8000_0001, 1'b0);
        do_load(1'b1, 2'd2, 32'h64, 1'b0, 32'hF00D_CAFE, 1'b0);
        // R10 lane order flipped between request and return
        do_load(1'b1, 2'd0, 32'h71, 1'b0, 32'h1122_3344, 1'b1);
        do_load(1'b0, 2'd1, 32'h72, 1'b1, 32'hC001_0203, 1'b1);

        repeat (3) @(negedge clk);
        chk("R10 all results seen", exp_q.size(), 32'd0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule